// File: doc/BRIEF.md
# Fixed-Point Polynomial Convolution Engine

The engine multiplies two polynomials of degree P. The caller writes the P+1 coefficients of each operand one at a time into two on-chip operand banks, then raises a start pulse. The engine returns the 2P+1 product coefficients as a stream, lowest index first, one per clock. After the last coefficient it pulses a completion flag.

All values are signed 32-bit fixed-point numbers carrying 7 fraction bits, so a real value r is held as floor(r * 128). A combinational array of P+1 multipliers works against a sliding, zero-padded window of the second operand. Each lane's 64-bit product is scaled back by 7 bits before the lanes are summed. A sum that does not fit in 32 bits is clamped to the nearest limit and sets a sticky overflow flag.

Top module: `polyconv_engine`

## Requirements
- R1: A coefficient is written on each clock where `ld_valid` is high and the engine is idle. `ld_sel`=0 selects operand A and `ld_sel`=1 selects operand B. Each operand has its own index, which starts at 0, advances by one per write, returns to 0 after index P, and is cleared to 0 when a start is accepted.
- R2: A start is accepted when `start` is high at a clock edge while the engine is idle. The 2P+1 results then appear on consecutive cycles with `res_valid` high. The first result appears one cycle after the cycle that follows acceptance.
- R3: Result n equals the sum over k of floor(A[k]*B[n-k] / 128), with terms outside index range 0..P taken as zero. Results come out in increasing order of n.
- R4: A sum above 2^31-1 is output as 32'h7FFFFFFF, and a sum below -2^31 is output as 32'h80000000.
- R5: `ovf` goes high in the same cycle as the first clamped result. It stays high until the next accepted start clears it.
- R6: A `start` raised while a computation is running has no effect. Exactly 2P+1 results are produced and no further run follows.
- R7: Coefficient writes presented while a computation is running are discarded. They change neither operand bank nor either write index.
- R8: `done` is high for exactly one cycle, the cycle right after the last result, and `res_valid` is low in that cycle.
- R9: While `rst_n` is low, `res_valid`, `done` and `ovf` are low and `res_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Coefficient write strobe |
| ld_sel | input | 1 | Operand select for the write (0 = A, 1 = B) |
| ld_data | input | 32 | Coefficient value, 7 fraction bits |
| start | input | 1 | Begin a convolution |
| res_valid | output | 1 | A result is on `res_data` |
| res_data | output | 32 | Product coefficient, 7 fraction bits |
| done | output | 1 | Single-cycle pulse after the last result |
| ovf | output | 1 | Sticky flag, set by a clamped result |

## Verification
The assertions assume that `start` and all loads are sampled synchronously and that `rst_n` is released only between edges. They also assume that clamping is the only source of `ovf`. Given these, an overflow rise always coincides with a limit value on the output. The bench keeps within these assumptions by driving every input on the falling edge. It also drives start and write pulses during a run on purpose, so that the ignore rules are exercised rather than avoided. Operand values are drawn from a bounded range for the normal-result sweep and pushed to the 2^30 magnitude only for the clamping cases.

// File: rtl/polyconv_pkg.sv
package polyconv_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;

  function automatic int ptr_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/polyconv_bank.sv
module polyconv_bank #(
  parameter int P = 3,
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [W-1:0]         wr_data,
  input  logic                 ptr_clr,
  output logic [P:0][W-1:0]    a_q,
  output logic [P:0][W-1:0]    b_q
);
  localparam int PW = polyconv_pkg::ptr_bits(P + 1);
  localparam logic [PW-1:0] LASTP = PW'(P);

  logic [PW-1:0] pa_q, pb_q, pa_n, pb_n;
  logic          wa, wb;

  assign wa = wr_en && !wr_sel;
  assign wb = wr_en &&  wr_sel;

  always_comb begin
    pa_n = pa_q;
    pb_n = pb_q;
    if (ptr_clr) begin
      pa_n = '0;
      pb_n = '0;
    end else begin
      if (wa) pa_n = (pa_q == LASTP) ? '0 : pa_q + 1'b1;
      if (wb) pb_n = (pb_q == LASTP) ? '0 : pb_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      pb_q <= '0;
    end else begin
      pa_q <= pa_n;
      pb_q <= pb_n;
    end
  end

  for (genvar i = 0; i <= P; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q[i] <= '0;
        b_q[i] <= '0;
      end else begin
        if (wa && pa_q == PW'(i)) a_q[i] <= wr_data;
        if (wb && pb_q == PW'(i)) b_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/polyconv_window.sv
module polyconv_window #(
  parameter int P = 3,
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [P:0][W-1:0] b_in,
  output logic [P:0][W-1:0] win_q
);
  // Feed queue holds B[1..P]; zeros enter behind it (the padding).
  logic [P-1:0][W-1:0] feed_q, feed_n;
  logic [P:0][W-1:0]   win_n;

  always_comb begin
    win_n  = win_q;
    feed_n = feed_q;
    if (load) begin
      win_n    = '0;
      win_n[0] = b_in[0];
      for (int j = 0; j < P; j++) feed_n[j] = b_in[j+1];
    end else if (shift) begin
      win_n[0] = feed_q[0];
      for (int k = 1; k <= P; k++) win_n[k] = win_q[k-1];
      for (int j = 0; j < P - 1; j++) feed_n[j] = feed_q[j+1];
      feed_n[P-1] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      feed_q <= '0;
    end else if (load || shift) begin
      win_q  <= win_n;
      feed_q <= feed_n;
    end
  end
endmodule

// File: rtl/polyconv_mac.sv
module polyconv_mac #(
  parameter int P    = 3,
  parameter int W    = 32,
  parameter int FRAC = 7
) (
  input  logic [P:0][W-1:0] a_in,
  input  logic [P:0][W-1:0] w_in,
  output logic [W-1:0]      sum_out,
  output logic              clamp
);
  localparam int SW = 2 * W + $clog2(P + 1) + 1;
  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (W - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(64'sd1 <<< (W - 1));

  logic signed [P:0][SW-1:0] term;
  logic signed [SW-1:0]      acc;

  for (genvar k = 0; k <= P; k++) begin : g_lane
    logic signed [2*W-1:0] prod;
    assign prod    = $signed(a_in[k]) * $signed(w_in[k]);
    assign term[k] = SW'(prod >>> FRAC);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k <= P; k++) acc = acc + term[k];
    clamp = 1'b0;
    if (acc > MAXV) begin
      sum_out = {1'b0, {(W-1){1'b1}}};
      clamp   = 1'b1;
    end else if (acc < MINV) begin
      sum_out = {1'b1, {(W-1){1'b0}}};
      clamp   = 1'b1;
    end else begin
      sum_out = acc[W-1:0];
    end
  end
endmodule

// File: rtl/polyconv_engine.sv
module polyconv_engine #(
  parameter int P    = 3,
  parameter int W    = 32,
  parameter int FRAC = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_valid,
  input  logic         ld_sel,
  input  logic [W-1:0] ld_data,
  input  logic         start,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         done,
  output logic         ovf
);
  import polyconv_pkg::*;

  localparam int NOUT = 2 * P + 1;
  localparam int SCW  = ptr_bits(NOUT);
  localparam logic [SCW-1:0] LAST = SCW'(NOUT - 1);

  run_state_t     st_q, st_n;
  logic           busy_q;
  logic [SCW-1:0] step_q, step_n;
  logic           accept, wr_en, last_step;
  logic           rv_n, last_q, last_n, ovf_n;
  logic [W-1:0]   rd_n, mac_sum;
  logic           mac_clamp;
  logic [P:0][W-1:0] a_q, b_q, win_q;

  assign busy_q    = (st_q == ST_RUN);
  assign accept    = start && !busy_q;
  assign wr_en     = ld_valid && !busy_q;
  assign last_step = busy_q && (step_q == LAST);

  polyconv_bank #(.P(P), .W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(ld_sel),
    .wr_data(ld_data), .ptr_clr(accept), .a_q(a_q), .b_q(b_q)
  );

  polyconv_window #(.P(P), .W(W)) u_win (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(busy_q),
    .b_in(b_q), .win_q(win_q)
  );

  polyconv_mac #(.P(P), .W(W), .FRAC(FRAC)) u_mac (
    .a_in(a_q), .w_in(win_q), .sum_out(mac_sum), .clamp(mac_clamp)
  );

  always_comb begin
    st_n   = st_q;
    step_n = step_q;
    if (accept) begin
      st_n   = ST_RUN;
      step_n = '0;
    end else if (busy_q) begin
      step_n = step_q + 1'b1;
      if (last_step) st_n = ST_IDLE;
    end
    rv_n   = busy_q;
    rd_n   = busy_q ? mac_sum : res_data;
    last_n = last_step;
    ovf_n  = ovf;
    if (accept)                      ovf_n = 1'b0;
    else if (busy_q && mac_clamp)    ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      step_q    <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      last_q    <= 1'b0;
      done      <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      st_q      <= st_n;
      step_q    <= step_n;
      res_valid <= rv_n;
      res_data  <= rd_n;
      last_q    <= last_n;
      done      <= last_q;
      ovf       <= ovf_n;
    end
  end
endmodule

// File: rtl/polyconv_chk.sv
module polyconv_chk #(
  parameter int P = 3,
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy_q,
  input logic         res_valid,
  input logic [W-1:0] res_data,
  input logic         done,
  input logic         ovf
);
  localparam int NOUT = 2 * P + 1;
  localparam int CW   = $clog2(NOUT + 2);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (start && !busy_q) seen_q <= '0;
    else if (res_valid && seen_q < CW'(NOUT + 1)) seen_q <= seen_q + 1'b1;
  end

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!res_valid && $past(res_valid)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(start && !busy_q)) |=> ovf);

  // R4
  clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (res_valid && (res_data == {1'b0, {(W-1){1'b1}}} ||
                                  res_data == {1'b1, {(W-1){1'b0}}})));

  // R6
  result_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (seen_q < CW'(NOUT)));
endmodule

bind polyconv_engine polyconv_chk #(.P(P), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy_q(busy_q),
  .res_valid(res_valid), .res_data(res_data), .done(done), .ovf(ovf)
);

// File: tb/sim_polyconv_engine.sv
module sim_polyconv_engine;
  localparam int P = 3;
  localparam int N = 2 * P + 1;

  logic clk = 1'b0;
  logic rst_n, ld_valid, ld_sel, start;
  logic [31:0] ld_data, res_data;
  logic res_valid, done, ovf;

  always #10 clk = ~clk;

  polyconv_engine u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .ld_data(ld_data), .start(start), .res_valid(res_valid),
    .res_data(res_data), .done(done), .ovf(ovf)
  );

  int total = 0, bad = 0;
  longint am [P+1];
  longint bm [P+1];
  longint ec [N];
  bit     eo;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint sat(input longint s);
    if (s > 64'sd2147483647) return 64'sd2147483647;
    if (s < -64'sd2147483648) return -64'sd2147483648;
    return s;
  endfunction

  task automatic model();
    eo = 1'b0;
    for (int n = 0; n < N; n++) begin
      longint s = 0;
      for (int k = 0; k <= P; k++)
        if (n - k >= 0 && n - k <= P) s += (am[k] * bm[n-k]) >>> 7;
      ec[n] = sat(s);
      if (ec[n] != s) eo = 1'b1;
    end
  endtask

  task automatic load_op(input bit sel, input longint v []);
    foreach (v[i]) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_sel = sel; ld_data = v[i][31:0];
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run(input bit poke, input string tag);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(ovf == 1'b0, "R5 cleared on start", ovf, 0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      chk(res_valid == 1'b1, "R2 valid", res_valid, 1);
      chk($signed(res_data) == ec[i], {"R3 value ", tag}, $signed(res_data), ec[i]);
      if (poke && i == 1) start = 1'b1;
      if (poke && i == 2) begin
        start = 1'b0;
        ld_valid = 1'b1; ld_sel = 1'b0; ld_data = 32'd777777;
      end
      if (poke && i == 3) begin
        ld_valid = 1'b1; ld_sel = 1'b1; ld_data = 32'd555555;
      end
      if (poke && i == 4) ld_valid = 1'b0;
    end
    @(negedge clk);
    chk(done == 1'b1 && res_valid == 1'b0, "R8 done after last", done, 1);
    chk(ovf == eo, "R5 sticky flag", ovf, eo);
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", done, 0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R6 no extra run", res_valid, 0);
    end
  endtask

  function automatic longint rnd(input int span);
    seed = seed * 1103515245 + 12345;
    return longint'(int'(seed % (2 * span + 1))) - span;
  endfunction

  task automatic load_model();
    longint va [] = new[P+1];
    longint vb [] = new[P+1];
    for (int i = 0; i <= P; i++) begin va[i] = am[i]; vb[i] = bm[i]; end
    load_op(1'b0, va);
    load_op(1'b1, vb);
  endtask

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; ld_sel = 1'b0; ld_data = '0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(res_valid == 0 && done == 0 && ovf == 0 && res_data == 0, "R9 reset state",
        {res_valid, done, ovf}, 0);
    rst_n = 1'b1;

    // Identity: A = 1.0, so C equals B (R3)
    for (int i = 0; i <= P; i++) begin am[i] = (i == 0) ? 128 : 0; bm[i] = 100 * (i + 1) - 250; end
    load_model(); model(); run(1'b0, "identity");

    // Sweep of bounded signed operands (R3)
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i <= P; i++) begin am[i] = rnd(40000); bm[i] = rnd(40000); end
      load_model(); model(); run(1'b0, "sweep");
    end

    // Start and writes during a run are ignored (R6, R7)
    for (int i = 0; i <= P; i++) begin am[i] = rnd(3000); bm[i] = rnd(3000); end
    load_model(); model(); run(1'b1, "poke");
    run(1'b0, "R7 banks kept");

    // Write index wraps after P (R1): P+2 writes to A, A[0] replaced
    begin
      longint v [] = new[P+2];
      for (int i = 0; i <= P + 1; i++) v[i] = 64 * (i + 1);
      load_op(1'b0, v);
      for (int i = 0; i <= P; i++) am[i] = v[i];
      am[0] = v[P+1];
      model(); run(1'b0, "R1 wrap");
    end

    // Clamping positive then negative, flag sticky and cleared (R4, R5)
    for (int i = 0; i <= P; i++) begin am[i] = 64'sd1 <<< 30; bm[i] = 64'sd1 <<< 30; end
    load_model(); model(); run(1'b0, "R4 high clamp");
    for (int i = 0; i <= P; i++) bm[i] = -(64'sd1 <<< 30);
    load_model(); model(); run(1'b0, "R4 low clamp");
    for (int i = 0; i <= P; i++) begin am[i] = 256; bm[i] = -384; end
    load_model(); model(); run(1'b0, "R5 clear");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule